// File: doc/BRIEF.md
# Load/Store Port Rule Monitor

This block is a passive watcher placed on a single load/store port, between the unit that issues memory requests and the unit that answers them. It drives nothing back onto the port. Each cycle it samples the request lines, the address qualifier and value, the busy line, the address acknowledge, the exception line and the two data strobes. It then decides whether either side has broken the timing contract of the port. Every rule has its own bit in an error bitmap. A bit stays set until the clear input is pulsed.

The monitor follows each transaction through four phases: idle, waiting for the acknowledge, waiting for data, and waiting for busy to drop after a store. Each rule is judged only in the phase where it means something. The code of the earliest violation is held on its own output, so a burst of follow-on errors does not hide the root cause. A saturating counter per rule records how often each rule was broken. The data buses are not examined, and no memory is modelled.

Top module: `lsport_monitor`

## Requirements
- R1: When `ld_req` and `st_req` are both high in the same cycle, bit 0 of `err_map` is set.
- R2: A request edge (`ld_req|st_req` high after being low in the previous cycle) that arrives while `busy` was high in the previous cycle sets bit 1.
- R3: A request edge in a cycle where `busy` is low sets bit 2.
- R4: After the address has been presented (`addr_vld` high with `busy` high inside a transaction), a cycle with `busy` still high in which `addr_vld` is low or `addr_val` differs from the value first presented sets bit 3. This applies until the transaction leaves its active phases.
- R5: A strobe that is high in two consecutive cycles sets one bit: `addr_ack` sets bit 4, `exc` sets bit 5, `ld_stb` sets bit 6 and `st_stb` sets bit 7.
- R6: A `st_stb` that is not preceded, in an earlier cycle of the current transaction, by an `addr_ack` sets bit 8.
- R7: `exc` together with `busy` high in the same cycle sets bit 9. `ld_stb` together with `busy` high sets bit 10.
- R8: `busy` high in the cycle right after a `st_stb` sets bit 11.
- R9: `addr_ack` and `exc` both occurring between one request edge and the next, in the same cycle or in different cycles, sets bit 12.
- R10: Error bits become visible one cycle after the offending cycle and stay set until `err_clr` is high. A violation in the same cycle as `err_clr` is still recorded.
- R11: `first_code` is 0 while no error is recorded. Otherwise it is the bit index plus one of the lowest-numbered rule broken in the first violating cycle after reset or clear. It holds that value until cleared.
- R12: Rule i has a counter at `viol_cnt[i*CNTW +: CNTW]`. The counter adds one per violating cycle, stops at 2^CNTW-1 and is zeroed by `err_clr`.
- R13: After reset, `err_map`, `first_code` and every counter are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_req | input | 1 | Load request line |
| st_req | input | 1 | Store request line |
| addr_vld | input | 1 | Address qualifier |
| addr_val | input | AW | Address value |
| busy | input | 1 | Responder busy |
| addr_ack | input | 1 | Address accepted pulse |
| exc | input | 1 | Exception pulse |
| ld_stb | input | 1 | Load data strobe |
| st_stb | input | 1 | Store data strobe |
| err_clr | input | 1 | Clears bitmap, first code and counters |
| err_map | output | 13 | Sticky per-rule error bits |
| first_code | output | 4 | Index plus one of the first rule broken, 0 if none |
| viol_cnt | output | 13*CNTW | Packed per-rule saturating counters |

## Verification
Two functions can meet in one cycle: the clear pulse and the recording of a fresh violation. The bench provokes this by holding both request lines high while it pulses `err_clr`. It then expects only the fresh bit, a first code naming that rule, and a counter of one. The bench also makes an acknowledge coincide with an exception, and a request edge coincide with an earlier sticky error. In each case the phase tracking, the first code and the counters are compared on every clock against a behavioural model.

// File: rtl/lsmon_pkg.sv
package lsmon_pkg;

   localparam int NRULE = 13;
   localparam int CODEW = $clog2(NRULE + 1);

   localparam int RB_BOTH    = 0;
   localparam int RB_REBUSY  = 1;
   localparam int RB_NOBUSY  = 2;
   localparam int RB_ADDR    = 3;
   localparam int RB_PULSE   = 4;
   localparam int NSTROBE    = 4;
   localparam int RB_STNOACK = 8;
   localparam int RB_EXCBUSY = 9;
   localparam int RB_LDBUSY  = 10;
   localparam int RB_STREL   = 11;
   localparam int RB_ACKEXC  = 12;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ACK  = 2'd1,
      PH_DATA = 2'd2,
      PH_REL  = 2'd3
   } phase_t;

endpackage

// File: rtl/lsmon_phase.sv
module lsmon_phase
   import lsmon_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_edge,
   input  logic          busy,
   input  logic          addr_vld,
   input  logic [AW-1:0] addr_val,
   input  logic          addr_ack,
   input  logic          exc,
   input  logic          ld_stb,
   input  logic          st_stb,
   output phase_t        ph_reg,
   output phase_t        ph_cur,
   output logic          ack_seen,
   output logic          exc_seen,
   output logic          addr_held,
   output logic [AW-1:0] addr_ref
);

   phase_t        ph_q, ph_d, cur;
   logic          ack_q, exc_q, held_q;
   logic          ack_c, exc_c, held_c, cap;
   logic [AW-1:0] addr_q;

   // effective state in this cycle: a request edge opens a new transaction,
   // the release phase lasts exactly one cycle
   always_comb begin
      if (req_edge)
         cur = PH_ACK;
      else if (ph_q == PH_REL)
         cur = PH_IDLE;
      else
         cur = ph_q;
      ack_c  = req_edge ? 1'b0 : ack_q;
      exc_c  = req_edge ? 1'b0 : exc_q;
      held_c = req_edge ? 1'b0 : held_q;
      cap    = !held_c && addr_vld && busy && (cur != PH_IDLE);
   end

   always_comb begin
      ph_d = cur;
      if (addr_ack && (cur == PH_ACK))
         ph_d = PH_DATA;
      if (st_stb)
         ph_d = PH_REL;
      if (ld_stb || exc)
         ph_d = PH_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         ack_q  <= 1'b0;
         exc_q  <= 1'b0;
         held_q <= 1'b0;
         addr_q <= '0;
      end else begin
         ph_q   <= ph_d;
         ack_q  <= ack_c | addr_ack;
         exc_q  <= exc_c | exc;
         held_q <= held_c | cap;
         if (cap)
            addr_q <= addr_val;
      end
   end

   assign ph_reg    = ph_q;
   assign ph_cur    = cur;
   assign ack_seen  = ack_c;
   assign exc_seen  = exc_c;
   assign addr_held = held_c;
   assign addr_ref  = addr_q;

endmodule

// File: rtl/lsmon_rules.sv
module lsmon_rules
   import lsmon_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_req,
   input  logic             st_req,
   input  logic             addr_vld,
   input  logic [AW-1:0]    addr_val,
   input  logic             busy,
   input  logic             addr_ack,
   input  logic             exc,
   input  logic             ld_stb,
   input  logic             st_stb,
   input  phase_t           ph_reg,
   input  phase_t           ph_cur,
   input  logic             ack_seen,
   input  logic             exc_seen,
   input  logic             addr_held,
   input  logic [AW-1:0]    addr_ref,
   output logic             req_edge,
   output logic [NRULE-1:0] viol
);

   logic               req_p, busy_p;
   logic [NSTROBE-1:0] stb_now, stb_p;
   logic               any_req;
   logic [NSTROBE-1:0] pulse_long;

   assign any_req  = ld_req | st_req;
   assign req_edge = any_req & ~req_p;
   assign stb_now  = {st_stb, ld_stb, exc, addr_ack};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_p  <= 1'b0;
         busy_p <= 1'b0;
         stb_p  <= '0;
      end else begin
         req_p  <= any_req;
         busy_p <= busy;
         stb_p  <= stb_now;
      end
   end

   // one detector per single-cycle strobe
   for (genvar k = 0; k < NSTROBE; k++) begin : g_pulse
      assign pulse_long[k] = stb_now[k] & stb_p[k];
   end

   always_comb begin
      viol = '0;
      viol[RB_BOTH]    = ld_req & st_req;
      viol[RB_REBUSY]  = req_edge & busy_p;
      viol[RB_NOBUSY]  = req_edge & ~busy;
      viol[RB_ADDR]    = busy && addr_held && (ph_cur != PH_IDLE) &&
                         (!addr_vld || (addr_val != addr_ref));
      viol[RB_PULSE +: NSTROBE] = pulse_long;
      viol[RB_STNOACK] = st_stb && (ph_cur != PH_DATA);
      viol[RB_EXCBUSY] = exc & busy;
      viol[RB_LDBUSY]  = ld_stb & busy;
      viol[RB_STREL]   = (ph_reg == PH_REL) && busy;
      viol[RB_ACKEXC]  = (addr_ack & exc) | (exc & ack_seen) | (addr_ack & exc_seen);
   end

endmodule

// File: rtl/lsmon_log.sv
module lsmon_log #(
   parameter int NR      = 13,
   parameter int CW      = 4,
   parameter int CNTW    = 8,
   parameter int SAT_CNT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NR-1:0]    viol,
   input  logic             clr,
   output logic [NR-1:0]    err_map,
   output logic [CW-1:0]    first_code,
   output logic [NR*CNTW-1:0] cnt_flat
);

   logic [NR-1:0] map_q, map_base;
   logic [CW-1:0] code_q, code_base, lo_code;

   always_comb begin
      map_base  = clr ? '0 : map_q;
      code_base = clr ? '0 : code_q;
      lo_code   = '0;
      for (int i = NR - 1; i >= 0; i--) begin
         if (viol[i])
            lo_code = CW'(i + 1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         map_q  <= '0;
         code_q <= '0;
      end else begin
         map_q <= map_base | viol;
         if ((code_base == '0) && (|viol))
            code_q <= lo_code;
         else
            code_q <= code_base;
      end
   end

   for (genvar g = 0; g < NR; g++) begin : g_cnt
      logic [CNTW-1:0] c_q, c_base;
      assign c_base = clr ? '0 : c_q;
      if (SAT_CNT != 0) begin : g_sat
         always_ff @(posedge clk) begin
            if (!rst_n)
               c_q <= '0;
            else if (viol[g] && (c_base != {CNTW{1'b1}}))
               c_q <= c_base + 1'b1;
            else
               c_q <= c_base;
         end
      end else begin : g_wrap
         always_ff @(posedge clk) begin
            if (!rst_n)
               c_q <= '0;
            else
               c_q <= c_base + CNTW'(viol[g]);
         end
      end
      assign cnt_flat[g*CNTW +: CNTW] = c_q;
   end

   assign err_map    = map_q;
   assign first_code = code_q;

endmodule

// File: rtl/lsport_monitor.sv
module lsport_monitor
   import lsmon_pkg::*;
#(
   parameter int AW      = 32,
   parameter int CNTW    = 8,
   parameter int SAT_CNT = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ld_req,
   input  logic                  st_req,
   input  logic                  addr_vld,
   input  logic [AW-1:0]         addr_val,
   input  logic                  busy,
   input  logic                  addr_ack,
   input  logic                  exc,
   input  logic                  ld_stb,
   input  logic                  st_stb,
   input  logic                  err_clr,
   output logic [NRULE-1:0]      err_map,
   output logic [CODEW-1:0]      first_code,
   output logic [NRULE*CNTW-1:0] viol_cnt
);

   if (AW < 1 || AW > 64) begin : g_bad_aw
      $error("lsport_monitor: AW out of range");
   end
   if (CNTW < 1 || CNTW > 32) begin : g_bad_cntw
      $error("lsport_monitor: CNTW out of range");
   end
   if (RB_PULSE + NSTROBE != RB_STNOACK) begin : g_bad_map
      $error("lsport_monitor: rule bit layout inconsistent");
   end

   logic             req_edge;
   phase_t           ph_reg, ph_cur;
   logic             ack_seen, exc_seen, addr_held;
   logic [AW-1:0]    addr_ref;
   logic [NRULE-1:0] viol;

   lsmon_phase #(.AW(AW)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_edge  (req_edge),
      .busy      (busy),
      .addr_vld  (addr_vld),
      .addr_val  (addr_val),
      .addr_ack  (addr_ack),
      .exc       (exc),
      .ld_stb    (ld_stb),
      .st_stb    (st_stb),
      .ph_reg    (ph_reg),
      .ph_cur    (ph_cur),
      .ack_seen  (ack_seen),
      .exc_seen  (exc_seen),
      .addr_held (addr_held),
      .addr_ref  (addr_ref)
   );

   lsmon_rules #(.AW(AW)) u_rules (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_req    (ld_req),
      .st_req    (st_req),
      .addr_vld  (addr_vld),
      .addr_val  (addr_val),
      .busy      (busy),
      .addr_ack  (addr_ack),
      .exc       (exc),
      .ld_stb    (ld_stb),
      .st_stb    (st_stb),
      .ph_reg    (ph_reg),
      .ph_cur    (ph_cur),
      .ack_seen  (ack_seen),
      .exc_seen  (exc_seen),
      .addr_held (addr_held),
      .addr_ref  (addr_ref),
      .req_edge  (req_edge),
      .viol      (viol)
   );

   lsmon_log #(
      .NR      (NRULE),
      .CW      (CODEW),
      .CNTW    (CNTW),
      .SAT_CNT (SAT_CNT)
   ) u_log (
      .clk        (clk),
      .rst_n      (rst_n),
      .viol       (viol),
      .clr        (err_clr),
      .err_map    (err_map),
      .first_code (first_code),
      .cnt_flat   (viol_cnt)
   );

endmodule

// File: rtl/lsport_monitor_chk.sv
module lsport_monitor_chk
   import lsmon_pkg::*;
#(
   parameter int CNTW    = 8,
   parameter int SAT_CNT = 1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  ld_req,
   input logic                  st_req,
   input logic                  busy,
   input logic                  addr_ack,
   input logic                  exc,
   input logic                  ld_stb,
   input logic                  err_clr,
   input logic [NRULE-1:0]      err_map,
   input logic [CODEW-1:0]      first_code,
   input logic [NRULE*CNTW-1:0] viol_cnt
);

   assert_both_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_req && st_req) |=> err_map[RB_BOTH]);

   assert_ack_long_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_ack && $past(addr_ack)) |=> err_map[RB_PULSE]);

   assert_exc_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (exc && busy) |=> err_map[RB_EXCBUSY]);

   assert_ld_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_stb && busy) |=> err_map[RB_LDBUSY]);

   assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !err_clr |=> ((err_map & $past(err_map)) == $past(err_map)));

   assert_code_pairs_map_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((err_map == '0) == (first_code == '0)));

   assert_code_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!err_clr && (first_code != '0)) |=> $stable(first_code));

   if (SAT_CNT != 0) begin : g_cnt_chk
      for (genvar g = 0; g < NRULE; g++) begin : g_rule
         assert_cnt_tracks_map_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (err_map[g] == (viol_cnt[g*CNTW +: CNTW] != '0)));
      end
   end

endmodule

bind lsport_monitor lsport_monitor_chk #(.CNTW(CNTW), .SAT_CNT(SAT_CNT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ld_req     (ld_req),
   .st_req     (st_req),
   .busy       (busy),
   .addr_ack   (addr_ack),
   .exc        (exc),
   .ld_stb     (ld_stb),
   .err_clr    (err_clr),
   .err_map    (err_map),
   .first_code (first_code),
   .viol_cnt   (viol_cnt)
);

// File: tb/sim_lsport_monitor.sv
`timescale 1ns/1ps
module sim_lsport_monitor;

   localparam int AW   = 32;
   localparam int CNTW = 3;
   localparam int NR   = 13;
   localparam int CMAX = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_req = 0, st_req = 0, addr_vld = 0, busy = 0;
   logic [AW-1:0] addr_val = '0;
   logic          addr_ack = 0, exc = 0, ld_stb = 0, st_stb = 0, err_clr = 0;
   logic [NR-1:0] err_map;
   logic [3:0]    first_code;
   logic [NR*CNTW-1:0] viol_cnt;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   always #5 clk = ~clk;

   lsport_monitor #(.AW(AW), .CNTW(CNTW), .SAT_CNT(1)) u0 (
      .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .st_req(st_req),
      .addr_vld(addr_vld), .addr_val(addr_val), .busy(busy),
      .addr_ack(addr_ack), .exc(exc), .ld_stb(ld_stb), .st_stb(st_stb),
      .err_clr(err_clr), .err_map(err_map), .first_code(first_code),
      .viol_cnt(viol_cnt)
   );

   // behavioural reference model
   logic [NR-1:0] e_map;
   int            e_code;
   int            e_cnt [NR];
   logic          p_req, p_busy, p_ack, p_exc, p_ld, p_st;
   int            m_ph;
   logic          m_ack, m_exc, m_held;
   logic [AW-1:0] m_addr;

   always @(posedge clk) begin
      logic [NR-1:0] v;
      logic rq, rq_edge, aseen, xseen, held;
      int cur, nph;
      if (!rst_n) begin
         e_map = '0; e_code = 0;
         for (int i = 0; i < NR; i++) e_cnt[i] = 0;
         p_req = 0; p_busy = 0; p_ack = 0; p_exc = 0; p_ld = 0; p_st = 0;
         m_ph = 0; m_ack = 0; m_exc = 0; m_held = 0; m_addr = '0;
      end else begin
         rq = ld_req | st_req;
         rq_edge = rq && !p_req;
         cur = rq_edge ? 1 : ((m_ph == 3) ? 0 : m_ph);
         aseen = rq_edge ? 1'b0 : m_ack;
         xseen = rq_edge ? 1'b0 : m_exc;
         held  = rq_edge ? 1'b0 : m_held;
         v = '0;
         v[0]  = ld_req && st_req;
         v[1]  = rq_edge && p_busy;
         v[2]  = rq_edge && !busy;
         v[3]  = busy && held && (cur != 0) && (!addr_vld || addr_val != m_addr);
         v[4]  = addr_ack && p_ack;
         v[5]  = exc && p_exc;
         v[6]  = ld_stb && p_ld;
         v[7]  = st_stb && p_st;
         v[8]  = st_stb && (cur != 2);
         v[9]  = exc && busy;
         v[10] = ld_stb && busy;
         v[11] = (m_ph == 3) && busy;
         v[12] = (addr_ack && exc) || (exc && aseen) || (addr_ack && xseen);
         nph = cur;
         if (addr_ack && cur == 1) nph = 2;
         if (st_stb) nph = 3;
         if (ld_stb || exc) nph = 0;
         if (!held && addr_vld && busy && cur != 0) begin
            m_addr = addr_val; held = 1'b1;
         end
         m_ph = nph; m_ack = aseen || addr_ack; m_exc = xseen || exc; m_held = held;
         p_req = rq; p_busy = busy; p_ack = addr_ack; p_exc = exc; p_ld = ld_stb; p_st = st_stb;
         if (err_clr) begin
            e_map = '0; e_code = 0;
            for (int i = 0; i < NR; i++) e_cnt[i] = 0;
         end
         for (int i = 0; i < NR; i++) begin
            if (v[i] && e_code == 0) e_code = i + 1;
            if (v[i] && e_cnt[i] < CMAX) e_cnt[i] = e_cnt[i] + 1;
         end
         e_map = e_map | v;
      end
   end

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit bad;
         bad = (err_map !== e_map) || (first_code !== e_code[3:0]);
         for (int i = 0; i < NR; i++)
            if (viol_cnt[i*CNTW +: CNTW] !== e_cnt[i][CNTW-1:0]) bad = 1;
         n_cmp++;
         if (bad) begin
            n_bad++;
            $display("FAIL R10/R11/R12 model: map=%h code=%0d cnt=%h exp map=%h code=%0d",
                     err_map, first_code, viol_cnt, e_map, e_code);
         end
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic l, input logic s, input logic av, input logic [AW-1:0] a,
                       input logic b, input logic k, input logic x, input logic ls,
                       input logic ss, input logic c);
      ld_req = l; st_req = s; addr_vld = av; addr_val = a; busy = b;
      addr_ack = k; exc = x; ld_stb = ls; st_stb = ss; err_clr = c;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      step(0, 0, 0, '0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic clear();
      step(0, 0, 0, '0, 0, 0, 0, 0, 0, 1);
      chk("R10 cleared", {51'd0, err_map}, 64'd0);
   endtask

   localparam logic [AW-1:0] A = 32'h0000_1040;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R13 reset map", {51'd0, err_map}, 64'd0);
      chk("R13 reset code", {60'd0, first_code}, 64'd0);
      chk("R13 reset counters", {25'd0, viol_cnt}, 64'd0);

      // clean load
      step(1,0,1,A,1,0,0,0,0,0); step(1,0,1,A,1,1,0,0,0,0);
      step(0,0,1,A,0,0,0,1,0,0); idle();
      chk("R7 clean load no flag", {51'd0, err_map}, 64'd0);
      // clean store
      step(0,1,1,A,1,0,0,0,0,0); step(0,1,1,A,1,1,0,0,0,0);
      step(0,1,1,A,1,0,0,0,1,0); step(0,0,0,A,0,0,0,0,0,0); idle();
      chk("R8 clean store no flag", {51'd0, err_map}, 64'd0);
      // clean exception
      step(1,0,1,A,1,0,0,0,0,0); step(0,0,1,A,0,0,1,0,0,0); idle();
      chk("R9 clean exception no flag", {51'd0, err_map}, 64'd0);

      // R1
      step(1,1,0,'0,1,0,0,0,0,0); step(0,0,0,'0,0,0,1,0,0,0); idle();
      chk("R1 both requests", {51'd0, err_map}, 64'h1);
      chk("R11 code for R1", {60'd0, first_code}, 64'd1);
      chk("R12 count one", {61'd0, viol_cnt[2:0]}, 64'd1);
      clear();
      // R2
      step(1,0,0,'0,1,0,0,0,0,0); step(0,0,0,'0,1,0,0,0,0,0);
      step(1,0,0,'0,1,0,0,0,0,0); step(0,0,0,'0,0,0,1,0,0,0); idle();
      chk("R2 request while busy", {51'd0, err_map}, 64'h2);
      chk("R11 code for R2", {60'd0, first_code}, 64'd2);
      clear();
      // R3
      step(1,0,0,'0,0,0,0,0,0,0); idle();
      chk("R3 request without busy", {51'd0, err_map}, 64'h4);
      clear();
      // R4 value change and qualifier drop
      step(1,0,1,32'h10,1,0,0,0,0,0); step(1,0,1,32'h11,1,0,0,0,0,0);
      step(0,0,0,'0,0,0,1,0,0,0); idle();
      chk("R4 address changed", {51'd0, err_map}, 64'h8);
      clear();
      step(0,1,1,32'h5,1,0,0,0,0,0); step(0,1,0,32'h5,1,0,0,0,0,0);
      step(0,0,0,'0,0,0,1,0,0,0); idle();
      chk("R4 address valid dropped", {51'd0, err_map}, 64'h8);
      clear();
      // R5 four strobes
      step(1,0,1,A,1,0,0,0,0,0); step(1,0,1,A,1,1,0,0,0,0); step(1,0,1,A,1,1,0,0,0,0);
      step(0,0,1,A,0,0,0,1,0,0); idle();
      chk("R5 ack two cycles", {51'd0, err_map}, 64'h10);
      clear();
      step(1,0,0,'0,1,0,0,0,0,0); step(0,0,0,'0,0,0,1,0,0,0); step(0,0,0,'0,0,0,1,0,0,0); idle();
      chk("R5 exc two cycles", {51'd0, err_map}, 64'h20);
      chk("R11 code for exc pulse", {60'd0, first_code}, 64'd6);
      clear();
      step(1,0,1,A,1,0,0,0,0,0); step(1,0,1,A,1,1,0,0,0,0);
      step(0,0,1,A,0,0,0,1,0,0); step(0,0,1,A,0,0,0,1,0,0); idle();
      chk("R5 load strobe two cycles", {51'd0, err_map}, 64'h40);
      clear();
      step(0,1,1,A,1,0,0,0,0,0); step(0,1,1,A,1,1,0,0,0,0);
      step(0,1,1,A,1,0,0,0,1,0); step(0,1,1,A,0,0,0,0,1,0); idle();
      chk("R5 store strobe two cycles", {51'd0, err_map}, 64'h180);
      chk("R11 code lowest of two", {60'd0, first_code}, 64'd8);
      clear();
      // R6
      step(0,1,1,A,1,0,0,0,0,0); step(0,1,1,A,1,0,0,0,1,0); step(0,0,0,'0,0,0,0,0,0,0); idle();
      chk("R6 store before ack", {51'd0, err_map}, 64'h100);
      clear();
      // R7
      step(1,0,0,'0,1,0,0,0,0,0); step(1,0,0,'0,1,0,1,0,0,0); idle();
      chk("R7 exception with busy", {51'd0, err_map}, 64'h200);
      clear();
      step(1,0,1,A,1,0,0,0,0,0); step(1,0,1,A,1,1,0,0,0,0); step(0,0,1,A,1,0,0,1,0,0); idle();
      chk("R7 load strobe with busy", {51'd0, err_map}, 64'h400);
      clear();
      // R8
      step(0,1,1,A,1,0,0,0,0,0); step(0,1,1,A,1,1,0,0,0,0);
      step(0,1,1,A,1,0,0,0,1,0); step(0,1,1,A,1,0,0,0,0,0); step(0,0,0,'0,0,0,0,0,0,0); idle();
      chk("R8 busy after store", {51'd0, err_map}, 64'h800);
      clear();
      // R9 separate and same cycle
      step(1,0,1,A,1,0,0,0,0,0); step(1,0,1,A,1,1,0,0,0,0); step(0,0,1,A,0,0,1,0,0,0); idle();
      chk("R9 ack then exception", {51'd0, err_map}, 64'h1000);
      clear();
      step(1,0,1,A,1,0,0,0,0,0); step(0,0,1,A,0,1,1,0,0,0); idle();
      chk("R9 ack with exception", {51'd0, err_map}, 64'h1000);
      clear();
      // R10 / R11 stickiness and clear colliding with a violation
      step(1,0,0,'0,0,0,0,0,0,0); idle(); idle();
      step(1,1,0,'0,1,0,0,0,0,0);
      chk("R10 bits accumulate", {51'd0, err_map}, 64'h5);
      chk("R11 code held", {60'd0, first_code}, 64'd3);
      step(1,1,0,'0,1,0,0,0,0,1);
      chk("R10 violation during clear kept", {51'd0, err_map}, 64'h1);
      chk("R11 code after clear collision", {60'd0, first_code}, 64'd1);
      chk("R12 counter restarted", {61'd0, viol_cnt[2:0]}, 64'd1);
      step(0,0,0,'0,0,0,1,0,0,0); idle();
      clear();
      // R12 saturation
      for (int i = 0; i < 10; i++) step(1,1,0,'0,1,0,0,0,0,0);
      chk("R12 counter saturates", {61'd0, viol_cnt[2:0]}, 64'd7);
      chk("R1 repeated", {51'd0, err_map}, 64'h1);
      step(0,0,0,'0,0,0,1,0,0,0); idle();
      clear();
      idle();

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule